// File: doc/BRIEF.md
# Byte pointer load/store unit

This unit reads and writes bit fields of variable width packed inside word-addressed memory. Each command carries a one-word descriptor that names a memory word, the bit offset of the field inside that word, and the field width in bits. A load returns the selected field right-justified and zero-extended. A store rewrites only the selected field through a read followed by a write. A step advances the descriptor to the following field, and a step-then-load does both in one command. Fields are taken from the most significant end of a word downwards. A field that would not fit in the remaining bits of the current word is never split: the descriptor moves on to the next word instead.

Commands arrive with a valid/ready handshake, and one command is in flight at a time. The memory side is a single-port interface. A request is a one-cycle pulse, and memory answers every request, read or write, with a one-cycle response pulse one or more cycles later. Each command ends with a one-cycle done pulse that carries the resulting descriptor and the loaded data.

Top module: `bptr_lsu`

## Requirements
- R1: Descriptor layout on 36-bit words: offset P in bits [35:30] (the number of bits to the right of the field), width S in bits [29:24], word address in bits [17:0]. Bits [23:18] are ignored on input and are zero in every returned descriptor.
- R2: cmd_op encodes 0 = load, 1 = store, 2 = step, 3 = step-then-load. cmd_ready is high when idle. A command is taken on an edge where cmd_valid and cmd_ready are both high. cmd_ready stays low from the next cycle until the cycle in which done pulses. Load, store and step-then-load make memory requests; a step makes none.
- R3: A load issues one read (mem_req_we = 0) at the descriptor address in the cycle after acceptance. done pulses in the cycle after the read response. done_data holds word bits P..P+S-1 right-justified and zero-extended; positions above bit 35 read as zero, and S = 0 gives 0. done_desc is the input descriptor.
- R4: A store reads the addressed word and, in the cycle after the read response, writes to the same address. The written word is the old word with bit P+i replaced by cmd_data bit i for every i < S with P+i <= 35; all other bits are unchanged. done pulses in the cycle after the write response, with done_data = 0 and done_desc = input descriptor.
- R5: A store with S = 0 still performs the read and the write, and the written word equals the word read.
- R6: A step with P >= S returns P' = P - S and the same address. done pulses in the cycle after acceptance with done_data = 0 and no memory request.
- R7: A step with P < S returns P' = 36 - S (modulo 64) and address + 1 (modulo 2^18); S is unchanged.
- R8: Step-then-load applies the step of R6/R7 first, then loads as in R3 through the new descriptor. The read goes to the new address, and done_desc is the new descriptor.
- R9: Every memory request lasts exactly one cycle, and the unit tolerates any response latency of one cycle or more.
- R10: After reset, cmd_ready is 1 and done and mem_req_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_op | input | 2 | Command code |
| cmd_desc | input | 36 | Descriptor word |
| cmd_data | input | 36 | Store value (low S bits used) |
| mem_req_valid | output | 1 | One-cycle memory request |
| mem_req_we | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | 18 | Word address of the request |
| mem_req_wdata | output | 36 | Word to write |
| mem_rsp_valid | input | 1 | One-cycle memory response |
| mem_rsp_rdata | input | 36 | Word read |
| done | output | 1 | One-cycle completion pulse |
| done_desc | output | 36 | Resulting descriptor |
| done_data | output | 36 | Loaded field, zero-extended |

## Verification
The bench targets the step that meets the word edge: offsets just below, equal to and above the width, zero width, and the address wrapping at the top of the space. A design with an off-by-one borrow test would split a field or skip a whole word. Fields that reach past bit 35 and stores of zero width are checked, because a wrong mask would either leak data bits into neighbouring fields or corrupt the word during the no-op write. Descriptors with reserved bits set, and response latencies from one to four cycles, would catch a design that echoes garbage or that samples memory data too early.

// File: rtl/bptr_pkg.sv
package bptr_pkg;
  localparam int unsigned BP_WORD_W = 36;
  localparam int unsigned BP_ADDR_W = 18;
  localparam int unsigned BP_FLD_W  = 6;

  typedef enum logic [1:0] {
    BP_LOAD      = 2'd0,
    BP_STORE     = 2'd1,
    BP_STEP      = 2'd2,
    BP_STEP_LOAD = 2'd3
  } bp_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } bp_state_e;
endpackage

// File: rtl/bptr_advance.sv
module bptr_advance #(
  parameter int unsigned WORD_W = 36,
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned FLD_W  = 6
) (
  input  logic [FLD_W-1:0]  pos_i,
  input  logic [FLD_W-1:0]  size_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [FLD_W-1:0]  pos_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [FLD_W-1:0] WORD_LEN = FLD_W'(WORD_W);

  // one extra bit carries the borrow of pos - size
  logic [FLD_W:0] diff;
  assign diff = {1'b0, pos_i} - {1'b0, size_i};

  always_comb begin
    if (diff[FLD_W]) begin
      pos_o  = WORD_LEN - size_i;
      addr_o = addr_i + ADDR_W'(1);
    end else begin
      pos_o  = diff[FLD_W-1:0];
      addr_o = addr_i;
    end
  end
endmodule

// File: rtl/bptr_field.sv
module bptr_field #(
  parameter int unsigned WORD_W = 36,
  parameter int unsigned FLD_W  = 6
) (
  input  logic [FLD_W-1:0]  pos_i,
  input  logic [FLD_W-1:0]  size_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] extract_o,
  output logic [WORD_W-1:0] merge_o
);
  localparam int unsigned SUM_W = FLD_W + 1;

  logic [SUM_W-1:0]  lo_edge;
  logic [SUM_W-1:0]  hi_edge;
  logic [WORD_W-1:0] mask;

  assign lo_edge = {1'b0, pos_i};
  assign hi_edge = {1'b0, pos_i} + {1'b0, size_i};

  // per-bit window test: bit b belongs to the field when pos <= b < pos+size
  generate
    for (genvar b = 0; b < WORD_W; b++) begin : g_mask
      localparam logic [SUM_W-1:0] BIT_IDX = SUM_W'(b);
      assign mask[b] = (BIT_IDX >= lo_edge) && (BIT_IDX < hi_edge);
    end
  endgenerate

  assign extract_o = (word_i & mask) >> pos_i;
  assign merge_o   = (word_i & ~mask) | ((data_i << pos_i) & mask);
endmodule

// File: rtl/bptr_lsu.sv
module bptr_lsu
  import bptr_pkg::*;
#(
  parameter int unsigned WORD_W = BP_WORD_W,
  parameter int unsigned ADDR_W = BP_ADDR_W,
  parameter int unsigned FLD_W  = BP_FLD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_desc,
  input  logic [WORD_W-1:0] cmd_data,
  output logic              mem_req_valid,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_rdata,
  output logic              done,
  output logic [WORD_W-1:0] done_desc,
  output logic [WORD_W-1:0] done_data
);
  localparam int unsigned POS_LSB  = WORD_W - FLD_W;
  localparam int unsigned SIZE_LSB = WORD_W - 2 * FLD_W;

  function automatic logic [WORD_W-1:0] pack_desc(
    input logic [FLD_W-1:0]  p,
    input logic [FLD_W-1:0]  s,
    input logic [ADDR_W-1:0] a
  );
    logic [WORD_W-1:0] r;
    r = '0;
    r[POS_LSB +: FLD_W]  = p;
    r[SIZE_LSB +: FLD_W] = s;
    r[ADDR_W-1:0]        = a;
    return r;
  endfunction

  // incoming descriptor fields
  bp_op_e            in_op;
  logic [FLD_W-1:0]  in_pos;
  logic [FLD_W-1:0]  in_size;
  logic [ADDR_W-1:0] in_addr;
  logic              rsvd_unused;

  assign in_op       = bp_op_e'(cmd_op);
  assign in_pos      = cmd_desc[POS_LSB +: FLD_W];
  assign in_size     = cmd_desc[SIZE_LSB +: FLD_W];
  assign in_addr     = cmd_desc[ADDR_W-1:0];
  assign rsvd_unused = ^cmd_desc[SIZE_LSB-1:ADDR_W];

  // stepped descriptor
  logic [FLD_W-1:0]  adv_pos;
  logic [ADDR_W-1:0] adv_addr;
  logic              do_step;
  logic [FLD_W-1:0]  sel_pos;
  logic [ADDR_W-1:0] sel_addr;

  bptr_advance #(
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W),
    .FLD_W  (FLD_W)
  ) u_advance (
    .pos_i  (in_pos),
    .size_i (in_size),
    .addr_i (in_addr),
    .pos_o  (adv_pos),
    .addr_o (adv_addr)
  );

  assign do_step  = (in_op == BP_STEP) || (in_op == BP_STEP_LOAD);
  assign sel_pos  = do_step ? adv_pos  : in_pos;
  assign sel_addr = do_step ? adv_addr : in_addr;

  // held command
  bp_state_e         state;
  bp_op_e            op_q;
  logic [FLD_W-1:0]  pos_q;
  logic [FLD_W-1:0]  size_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;

  logic [WORD_W-1:0] field_val;
  logic [WORD_W-1:0] merged_word;

  bptr_field #(
    .WORD_W (WORD_W),
    .FLD_W  (FLD_W)
  ) u_field (
    .pos_i     (pos_q),
    .size_i    (size_q),
    .word_i    (mem_rsp_rdata),
    .data_i    (data_q),
    .extract_o (field_val),
    .merge_o   (merged_word)
  );

  // registered outputs
  logic              req_valid_q;
  logic              req_we_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [WORD_W-1:0] req_wdata_q;
  logic              done_q;
  logic [WORD_W-1:0] done_desc_q;
  logic [WORD_W-1:0] done_data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      op_q        <= BP_LOAD;
      pos_q       <= '0;
      size_q      <= '0;
      addr_q      <= '0;
      data_q      <= '0;
      req_valid_q <= 1'b0;
      req_we_q    <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      done_q      <= 1'b0;
      done_desc_q <= '0;
      done_data_q <= '0;
    end else begin
      req_valid_q <= 1'b0;
      done_q      <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_q   <= in_op;
            pos_q  <= sel_pos;
            size_q <= in_size;
            addr_q <= sel_addr;
            data_q <= cmd_data;
            if (in_op == BP_STEP) begin
              done_q      <= 1'b1;
              done_desc_q <= pack_desc(sel_pos, in_size, sel_addr);
              done_data_q <= '0;
            end else begin
              req_valid_q <= 1'b1;
              req_we_q    <= 1'b0;
              req_addr_q  <= sel_addr;
              state       <= ST_RD;
            end
          end
        end
        ST_RD: begin
          if (mem_rsp_valid) begin
            if (op_q == BP_STORE) begin
              req_valid_q <= 1'b1;
              req_we_q    <= 1'b1;
              req_addr_q  <= addr_q;
              req_wdata_q <= merged_word;
              state       <= ST_WR;
            end else begin
              done_q      <= 1'b1;
              done_desc_q <= pack_desc(pos_q, size_q, addr_q);
              done_data_q <= field_val;
              state       <= ST_IDLE;
            end
          end
        end
        ST_WR: begin
          if (mem_rsp_valid) begin
            done_q      <= 1'b1;
            done_desc_q <= pack_desc(pos_q, size_q, addr_q);
            done_data_q <= '0;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready     = (state == ST_IDLE);
  assign mem_req_valid = req_valid_q;
  assign mem_req_we    = req_we_q;
  assign mem_req_addr  = req_addr_q;
  assign mem_req_wdata = req_wdata_q;
  assign done          = done_q;
  assign done_desc     = done_desc_q;
  assign done_data     = done_data_q;
endmodule

// File: rtl/bptr_lsu_chk.sv
module bptr_lsu_chk
  import bptr_pkg::*;
#(
  parameter int unsigned ADDR_W = BP_ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic              mem_req_valid,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              done
);
  logic [ADDR_W-1:0] last_rd_addr;

  always_ff @(posedge clk) begin
    if (rst) last_rd_addr <= '0;
    else if (mem_req_valid && !mem_req_we) last_rd_addr <= mem_req_addr;
  end

  p_req_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  p_req_busy_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !cmd_ready);

  p_wr_same_addr_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_we) |-> (mem_req_addr == last_rd_addr));

  p_wr_after_rsp_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_we) |-> $past(mem_rsp_valid));

  p_done_cause_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(mem_rsp_valid) ||
              $past(cmd_valid && cmd_ready && (cmd_op == BP_STEP))));
endmodule

bind bptr_lsu bptr_lsu_chk #(.ADDR_W(ADDR_W)) u_bptr_lsu_chk (
  .clk           (clk),
  .rst           (rst),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .cmd_op        (cmd_op),
  .mem_req_valid (mem_req_valid),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .done          (done)
);

// File: tb/bptr_lsu_tb_top.sv
module bptr_lsu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic [35:0] cmd_desc = '0;
  logic [35:0] cmd_data = '0;
  logic        mem_req_valid;
  logic        mem_req_we;
  logic [17:0] mem_req_addr;
  logic [35:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [35:0] mem_rsp_rdata;
  logic        done;
  logic [35:0] done_desc;
  logic [35:0] done_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  bptr_lsu dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_desc(cmd_desc), .cmd_data(cmd_data),
    .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .done(done), .done_desc(done_desc), .done_data(done_data)
  );

  // ---------------- helper functions (behavioural reference) -------------
  function automatic logic [35:0] pat(int i);
    logic [63:0] t;
    t = 64'h9E3779B97F4A7C15 * 64'(i + 1);
    return t[47:12];
  endfunction

  function automatic logic [35:0] mk_desc(int p, int s, int a);
    return {6'(p), 6'(s), 6'b0, 18'(a)};
  endfunction

  function automatic logic [35:0] ref_extract(logic [35:0] w, int p, int s);
    logic [35:0] r;
    r = '0;
    for (int i = 0; i < s; i++)
      if (p + i < 36) r[i] = w[p + i];
    return r;
  endfunction

  function automatic logic [35:0] ref_merge(logic [35:0] w, int p, int s, logic [35:0] v);
    logic [35:0] r;
    r = w;
    for (int i = 0; i < s; i++)
      if (p + i < 36) r[p + i] = v[i];
    return r;
  endfunction

  // ---------------- memory model ----------------
  logic [35:0] mem [64];
  int          lat = 1;
  int          cnt;
  logic [35:0] pend;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (rst) begin
      for (int i = 0; i < 64; i++) mem[i] <= pat(i);
      cnt <= 0;
    end else if (mem_req_valid) begin
      if (mem_req_we) mem[mem_req_addr[5:0]] <= mem_req_wdata;
      if (lat <= 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem[mem_req_addr[5:0]];
      end else begin
        cnt  <= lat - 1;
        pend <= mem[mem_req_addr[5:0]];
      end
    end else if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= pend;
      end
    end
  end

  // ---------------- checking ----------------
  int errors = 0;
  int checks = 0;
  int cyc    = 0;

  task automatic check(bit ok, string tag, string what, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference model state
  string       cur_tag = "R2";
  string       m_tag   = "R2";
  bit          busy_m  = 0;
  bit          exp_req = 0;
  bit          exp_we  = 0;
  logic [17:0] exp_addr;
  logic [35:0] exp_wdata;
  bit          exp_done = 0;
  logic [35:0] exp_desc;
  logic [35:0] exp_data;
  int          m_op, m_p, m_s, m_a;
  logic [35:0] m_data;
  bit          m_wr = 0;

  task automatic tick();
    bit n_req, n_done;
    @(negedge clk);
    cyc++;
    if (!rst) begin
      check(cmd_ready == !busy_m, "R2", "cmd_ready", 36'(cmd_ready), 36'(!busy_m));
      check(mem_req_valid == exp_req, exp_req ? m_tag : "R9", "mem_req_valid",
            36'(mem_req_valid), 36'(exp_req));
      if (exp_req && mem_req_valid) begin
        check(mem_req_we == exp_we, m_tag, "mem_req_we", 36'(mem_req_we), 36'(exp_we));
        check(mem_req_addr == exp_addr, m_tag, "mem_req_addr", 36'(mem_req_addr), 36'(exp_addr));
        if (exp_we)
          check(mem_req_wdata == exp_wdata, m_tag, "mem_req_wdata", mem_req_wdata, exp_wdata);
      end
      check(done == exp_done, m_tag, "done", 36'(done), 36'(exp_done));
      if (exp_done && done) begin
        check(done_desc == exp_desc, m_tag, "done_desc", done_desc, exp_desc);
        check(done_data == exp_data, m_tag, "done_data", done_data, exp_data);
      end
      // advance the model to the next cycle
      n_req  = 0;
      n_done = 0;
      if (cmd_valid && cmd_ready) begin
        m_tag  = cur_tag;
        m_op   = int'(cmd_op);
        m_p    = int'(cmd_desc[35:30]);
        m_s    = int'(cmd_desc[29:24]);
        m_a    = int'(cmd_desc[17:0]);
        m_data = cmd_data;
        if (m_op >= 2) begin
          if (m_p - m_s < 0) begin
            m_p = (36 - m_s) & 63;
            m_a = (m_a + 1) & 18'h3FFFF;
          end else begin
            m_p = m_p - m_s;
          end
        end
        if (m_op == 2) begin
          n_done   = 1;
          exp_desc = mk_desc(m_p, m_s, m_a);
          exp_data = '0;
        end else begin
          busy_m   = 1;
          n_req    = 1;
          exp_we   = 0;
          exp_addr = 18'(m_a);
          m_wr     = 0;
        end
      end
      if (mem_rsp_valid) begin
        if (m_op == 1 && !m_wr) begin
          n_req     = 1;
          exp_we    = 1;
          exp_addr  = 18'(m_a);
          exp_wdata = ref_merge(mem_rsp_rdata, m_p, m_s, m_data);
          m_wr      = 1;
        end else begin
          n_done   = 1;
          exp_desc = mk_desc(m_p, m_s, m_a);
          exp_data = (m_op == 1) ? 36'd0 : ref_extract(mem_rsp_rdata, m_p, m_s);
          busy_m   = 0;
        end
      end
      exp_req  = n_req;
      exp_done = n_done;
    end
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog R2: cycles %0d expected below %0d", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic run_cmd(int op, logic [35:0] d, logic [35:0] v, string tag);
    cur_tag = tag;
    while (!cmd_ready) tick();
    cmd_valid = 1'b1;
    cmd_op    = 2'(op);
    cmd_desc  = d;
    cmd_data  = v;
    tick();
    cmd_valid = 1'b0;
    while (busy_m || exp_done) tick();
  endtask

  initial begin
    logic [35:0] old;
    logic [35:0] wd;
    int wp, ws, wa;
    rst = 1'b1;
    repeat (4) tick();
    rst = 1'b0;
    // R10 reset state
    check(cmd_ready == 1'b1, "R10", "cmd_ready after reset", 36'(cmd_ready), 36'd1);
    check(done == 1'b0, "R10", "done after reset", 36'(done), 36'd0);
    check(mem_req_valid == 1'b0, "R10", "mem_req_valid after reset", 36'(mem_req_valid), 36'd0);
    tick();

    // loads, R3
    lat = 1;
    run_cmd(0, mk_desc(30, 6, 3), '0, "R3");
    run_cmd(0, mk_desc(0, 36, 5), '0, "R3");
    run_cmd(0, mk_desc(7, 13, 9), '0, "R3");
    lat = 4;
    run_cmd(0, mk_desc(33, 6, 10), '0, "R3");
    run_cmd(0, mk_desc(12, 0, 4), '0, "R3");
    // R1 reserved bits ignored and cleared
    run_cmd(0, mk_desc(4, 8, 2) | 36'h0_00FC_0000, '0, "R1");
    run_cmd(2, mk_desc(9, 3, 7) | 36'h0_0054_0000, '0, "R1");

    // stores, R4 / R5
    lat = 3;
    old = mem[6];
    run_cmd(1, mk_desc(10, 9, 6), 36'h9_8765_4321, "R4");
    check(mem[6] == ref_merge(old, 10, 9, 36'h9_8765_4321), "R4", "mem[6] after store",
          mem[6], ref_merge(old, 10, 9, 36'h9_8765_4321));
    old = mem[7];
    run_cmd(1, mk_desc(30, 6, 7), 36'hF_FFFF_FFC5, "R4");
    check(mem[7] == ref_merge(old, 30, 6, 36'h5), "R4", "mem[7] top field",
          mem[7], ref_merge(old, 30, 6, 36'h5));
    old = mem[8];
    run_cmd(1, mk_desc(5, 0, 8), 36'hF_FFFF_FFFF, "R5");
    check(mem[8] == old, "R5", "mem[8] zero-width store", mem[8], old);
    old = mem[9];
    run_cmd(1, mk_desc(32, 8, 9), 36'h0_0000_00AB, "R4");
    check(mem[9] == ref_merge(old, 32, 8, 36'hAB), "R4", "mem[9] clipped field",
          mem[9], ref_merge(old, 32, 8, 36'hAB));
    lat = 2;
    run_cmd(1, mk_desc(0, 36, 13), 36'h1_2345_6789, "R4");
    check(mem[13] == 36'h1_2345_6789, "R4", "mem[13] full word", mem[13], 36'h1_2345_6789);
    run_cmd(0, mk_desc(0, 36, 13), '0, "R4");

    // steps, R6 / R7
    run_cmd(2, mk_desc(12, 6, 20), '0, "R6");
    run_cmd(2, mk_desc(6, 6, 20), '0, "R6");
    run_cmd(2, mk_desc(3, 0, 20), '0, "R6");
    run_cmd(2, mk_desc(0, 6, 20), '0, "R7");
    run_cmd(2, mk_desc(5, 6, 20), '0, "R7");
    run_cmd(2, mk_desc(1, 7, 18'h3FFFF), '0, "R7");

    // step-then-load, R8
    lat = 1;
    run_cmd(3, mk_desc(2, 7, 11), '0, "R8");
    run_cmd(3, mk_desc(20, 7, 11), '0, "R8");
    wp = 36; ws = 7; wa = 12;
    for (int k = 0; k < 12; k++) begin
      lat = 1 + (k % 4);
      run_cmd(3, mk_desc(wp, ws, wa), '0, "R8");
      if (wp - ws < 0) begin
        wp = 36 - ws;
        wa = wa + 1;
      end else begin
        wp = wp - ws;
      end
    end
    // walk ends at word 14 after twelve 7-bit fields (five per word)
    wd = mk_desc(wp, ws, wa);
    check(wd[17:0] == 18'd14, "R8", "walk final address", 36'(wd[17:0]), 36'd14);

    repeat (3) tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule